// File: doc/BRIEF.md
# Packed Quotient-Remainder Divider

This block divides an integer dividend by a divisor over several clock cycles. It works at two sizes. In byte size a 16-bit dividend is divided by an 8-bit divisor. In word size a 32-bit dividend is divided by a 16-bit divisor. Each size has an unsigned mode and a signed mode. The quotient and the remainder come back together in one destination word. The low half of that word holds the truncated quotient and the high half holds the remainder. Two flags describe the quotient: a negative flag and a zero flag.

A request is a one-cycle `start` with the operands, `size_word` and `signed_mode` held on the inputs. While the division runs, `busy` stays high. A one-cycle `done` marks the cycle in which the result and the flags are valid. The core is a restoring divider that produces one quotient bit per clock. In signed mode it divides the magnitudes and then corrects the signs, so the quotient truncates toward zero and the remainder takes the sign of the dividend. A zero divisor is caught at the request and reported at once, and the previous result is left in place.

Top module: `dq_divider`

## Requirements
- R1: Byte size (`size_word`=0), unsigned: the dividend is `dividend[15:0]` and the divisor is `divisor[7:0]`. `result[7:0]` is the low 8 bits of the quotient, `result[15:8]` is the remainder and `result[31:16]` is zero.
- R2: Word size (`size_word`=1), unsigned: the dividend is `dividend[31:0]` and the divisor is `divisor[15:0]`. `result[15:0]` is the low 16 bits of the quotient and `result[31:16]` is the remainder.
- R3: Signed mode (`signed_mode`=1): each operand is sign-extended from its own width (16 or 8 bits in byte size, 32 or 16 bits in word size). The quotient truncates toward zero and the remainder has the sign of the dividend. Both are packed as in R1 and R2.
- R4: `flag_n` equals the top bit of the packed quotient field: bit 7 in byte size and bit 15 in word size. In signed mode this bit is the sign of the quotient.
- R5: `flag_z` is 1 exactly when the packed quotient field (8 bits in byte size, 16 bits in word size) is zero.
- R6: A `start` sampled while idle begins an operation. `busy` is high from the next cycle until `done`. `done` is a one-cycle pulse that comes 16 clock edges after the accepted start in byte size and 32 edges after it in word size, and `busy` is low while `done` is high. `result`, `flag_n` and `flag_z` change only together with `done`.
- R7: A zero divisor (`divisor[7:0]` in byte size, `divisor[15:0]` in word size) makes `done` pulse on the cycle after the start while `busy` stays low. In that case `div_by_zero` is set and `result`, `flag_n` and `flag_z` keep their old values. `div_by_zero` is cleared by the next accepted start that has a non-zero divisor.
- R8: A `start` that arrives while `busy` is high is ignored. It does not change the result of the running operation, when that operation completes, or any output.
- R9: After reset, `busy`, `done`, `result`, `flag_n`, `flag_z` and `div_by_zero` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled when idle |
| size_word | input | 1 | 0: 16/8 byte size, 1: 32/16 word size |
| signed_mode | input | 1 | 1: two's complement operands |
| dividend | input | 32 | Dividend; byte size uses bits 15:0 |
| divisor | input | 16 | Divisor; byte size uses bits 7:0 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed remainder (high) and quotient (low) |
| flag_n | output | 1 | Top bit of the packed quotient |
| flag_z | output | 1 | Packed quotient is zero |
| div_by_zero | output | 1 | Last accepted request had a zero divisor |

## Verification
Each clock, the bench compares every output against a behavioural model. So a fault in the step counter shows up as a `done` or `busy` mismatch on the exact edge where the timing is wrong. A fault in the remainder register, the quotient shift register or the sign latches does not appear until `done`. At that point it shows as a wrong packed word or a wrong flag, at most 32 cycles after the start. Zero-divisor and start-while-busy faults show up within one cycle as an early `done`, a `busy` that does not drop, or a changed result.

// File: rtl/dq_pkg.sv
package dq_pkg;
   typedef enum logic {
      DQ_SIZE_BYTE = 1'b0,
      DQ_SIZE_WORD = 1'b1
   } dq_size_e;
endpackage

// File: rtl/dq_prep.sv
// Operand preparation: size masking, sign extension, magnitude extraction.
module dq_prep
   import dq_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  dq_size_e                 size_sel,
   input  logic                     sgn,
   input  logic [2*HALF_W-1:0]      dividend,
   input  logic [HALF_W-1:0]        divisor,
   output logic [2*HALF_W-1:0]      dd_mag,
   output logic [HALF_W-1:0]        ds_mag,
   output logic                     neg_q,
   output logic                     neg_r,
   output logic                     ds_zero,
   output logic [$clog2(2*HALF_W+1)-1:0] steps
);
   localparam int DW   = 2 * HALF_W;
   localparam int LO_W = HALF_W / 2;
   localparam int CW   = $clog2(DW + 1);

   logic [HALF_W-1:0] dd_small;
   logic [LO_W-1:0]   ds_small;
   logic              dd_neg, ds_neg;

   always_comb begin
      dd_small = dividend[HALF_W-1:0];
      ds_small = divisor[LO_W-1:0];
      if (size_sel == DQ_SIZE_WORD) begin
         dd_neg  = sgn & dividend[DW-1];
         ds_neg  = sgn & divisor[HALF_W-1];
         dd_mag  = dd_neg ? (~dividend + 1'b1) : dividend;
         ds_mag  = ds_neg ? (~divisor + 1'b1) : divisor;
         ds_zero = (divisor == '0);
         steps   = CW'(DW);
      end else begin
         dd_neg  = sgn & dd_small[HALF_W-1];
         ds_neg  = sgn & ds_small[LO_W-1];
         // byte dividend is aligned to the top so the same shifter serves both sizes
         dd_mag  = {(dd_neg ? (~dd_small + 1'b1) : dd_small), {HALF_W{1'b0}}};
         ds_mag  = {{(HALF_W-LO_W){1'b0}}, (ds_neg ? (~ds_small + 1'b1) : ds_small)};
         ds_zero = (ds_small == '0);
         steps   = CW'(HALF_W);
      end
      neg_q = dd_neg ^ ds_neg;
      neg_r = dd_neg;
   end
endmodule

// File: rtl/dq_step.sv
// One restoring division step: shift in one dividend bit, trial subtract.
module dq_step #(
   parameter int HALF_W = 16
) (
   input  logic [HALF_W-1:0] rem_in,
   input  logic              dd_bit,
   input  logic [HALF_W-1:0] ds,
   output logic [HALF_W-1:0] rem_out,
   output logic              q_bit
);
   logic [HALF_W:0] partial;
   logic [HALF_W:0] diff;

   always_comb begin
      partial = {rem_in, dd_bit};
      diff    = partial - {1'b0, ds};
      q_bit   = (partial >= {1'b0, ds});
      rem_out = q_bit ? diff[HALF_W-1:0] : partial[HALF_W-1:0];
   end
endmodule

// File: rtl/dq_pack.sv
// Sign correction, packing of remainder/quotient, flag derivation.
module dq_pack
   import dq_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  dq_size_e             size_sel,
   input  logic                 neg_q,
   input  logic                 neg_r,
   input  logic [HALF_W-1:0]    q_lo,
   input  logic [HALF_W-1:0]    r_mag,
   output logic [2*HALF_W-1:0]  packed_word,
   output logic                 n_flag,
   output logic                 z_flag
);
   localparam int LO_W = HALF_W / 2;

   logic [HALF_W-1:0] q_fix, r_fix;

   always_comb begin
      q_fix = neg_q ? (~q_lo + 1'b1) : q_lo;
      r_fix = neg_r ? (~r_mag + 1'b1) : r_mag;
      if (size_sel == DQ_SIZE_WORD) begin
         packed_word = {r_fix, q_fix};
         n_flag      = q_fix[HALF_W-1];
         z_flag      = (q_fix == '0);
      end else begin
         packed_word = {{HALF_W{1'b0}}, r_fix[LO_W-1:0], q_fix[LO_W-1:0]};
         n_flag      = q_fix[LO_W-1];
         z_flag      = (q_fix[LO_W-1:0] == '0);
      end
   end
endmodule

// File: rtl/dq_divider.sv
module dq_divider
   import dq_pkg::*;
#(
   parameter int HALF_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  size_word,
   input  logic                  signed_mode,
   input  logic [2*HALF_W-1:0]   dividend,
   input  logic [HALF_W-1:0]     divisor,
   output logic                  busy,
   output logic                  done,
   output logic [2*HALF_W-1:0]   result,
   output logic                  flag_n,
   output logic                  flag_z,
   output logic                  div_by_zero
);
   localparam int DW = 2 * HALF_W;
   localparam int CW = $clog2(DW + 1);

   generate
      if (HALF_W < 4 || (HALF_W % 2) != 0) begin : g_bad_width
         $error("dq_divider: HALF_W must be even and at least 4");
      end
   endgenerate

   dq_size_e          size_in, size_q;
   logic [DW-1:0]     dd_mag, quo_q;
   logic [HALF_W-1:0] ds_mag, ds_q, rem_q, rem_nx;
   logic              neg_q_in, neg_r_in, negq_q, negr_q, ds_zero, q_bit;
   logic [CW-1:0]     steps, cnt_q;
   logic [DW-1:0]     quo_nx, pk_word;
   logic              pk_n, pk_z;
   logic              busy_q, done_q, n_q, z_q, dbz_q;
   logic [DW-1:0]     result_q;

   assign size_in = size_word ? DQ_SIZE_WORD : DQ_SIZE_BYTE;

   dq_prep #(.HALF_W(HALF_W)) u_prep (
      .size_sel (size_in),
      .sgn      (signed_mode),
      .dividend (dividend),
      .divisor  (divisor),
      .dd_mag   (dd_mag),
      .ds_mag   (ds_mag),
      .neg_q    (neg_q_in),
      .neg_r    (neg_r_in),
      .ds_zero  (ds_zero),
      .steps    (steps)
   );

   dq_step #(.HALF_W(HALF_W)) u_step (
      .rem_in  (rem_q),
      .dd_bit  (quo_q[DW-1]),
      .ds      (ds_q),
      .rem_out (rem_nx),
      .q_bit   (q_bit)
   );

   assign quo_nx = {quo_q[DW-2:0], q_bit};

   dq_pack #(.HALF_W(HALF_W)) u_pack (
      .size_sel    (size_q),
      .neg_q       (negq_q),
      .neg_r       (negr_q),
      .q_lo        (quo_nx[HALF_W-1:0]),
      .r_mag       (rem_nx),
      .packed_word (pk_word),
      .n_flag      (pk_n),
      .z_flag      (pk_z)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done_q   <= 1'b0;
         dbz_q    <= 1'b0;
         n_q      <= 1'b0;
         z_q      <= 1'b0;
         result_q <= '0;
         cnt_q    <= '0;
         rem_q    <= '0;
         quo_q    <= '0;
         ds_q     <= '0;
         size_q   <= DQ_SIZE_BYTE;
         negq_q   <= 1'b0;
         negr_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy_q   <= 1'b0;
               done_q   <= 1'b1;
               result_q <= pk_word;
               n_q      <= pk_n;
               z_q      <= pk_z;
            end
         end else if (start) begin
            dbz_q <= ds_zero;
            if (ds_zero) begin
               done_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               rem_q  <= '0;
               quo_q  <= dd_mag;
               ds_q   <= ds_mag;
               size_q <= size_in;
               negq_q <= neg_q_in;
               negr_q <= neg_r_in;
               cnt_q  <= steps;
            end
         end
      end
   end

   assign busy        = busy_q;
   assign done        = done_q;
   assign result      = result_q;
   assign flag_n      = n_q;
   assign flag_z      = z_q;
   assign div_by_zero = dbz_q;

   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   assert_count_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> cnt_q != '0);
   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && cnt_q != CW'(1)) |=> (busy && $stable(result)));
   assert_zero_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_by_zero) |-> ($stable(result) && $stable(flag_n) && $stable(flag_z)));
   assert_zero_never_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !div_by_zero);
   assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> rem_q < ds_q);
endmodule

// File: tb/tb_dq_divider.sv
module tb_dq_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        size_word = 1'b0;
   logic        signed_mode = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic        busy, done, flag_n, flag_z, div_by_zero;
   logic [31:0] result;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   string tag = "R9";

   // behavioural reference state
   logic        m_busy = 0, m_done = 0, m_n = 0, m_z = 0, m_dbz = 0;
   logic [31:0] m_res = '0;
   int          m_left = 0;
   logic [31:0] p_res;
   logic        p_n, p_z;

   always #5 clk = ~clk;

   dq_divider dut (
      .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word),
      .signed_mode(signed_mode), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .result(result), .flag_n(flag_n),
      .flag_z(flag_z), .div_by_zero(div_by_zero)
   );

   task automatic compute(input logic sz, input logic sg, input logic [31:0] a,
                          input logic [15:0] b, output logic zero);
      longint dd, ds, q, r;
      if (sz) begin
         dd = sg ? longint'($signed(a)) : longint'(a);
         ds = sg ? longint'($signed(b)) : longint'(b);
      end else begin
         dd = sg ? longint'($signed(a[15:0])) : longint'(a[15:0]);
         ds = sg ? longint'($signed(b[7:0])) : longint'(b[7:0]);
      end
      zero = (ds == 0);
      if (!zero) begin
         q = dd / ds;
         r = dd % ds;
         if (sz) begin
            p_res = {r[15:0], q[15:0]};
            p_n   = q[15];
            p_z   = (q[15:0] == 16'h0);
         end else begin
            p_res = {16'h0, r[7:0], q[7:0]};
            p_n   = q[7];
            p_z   = (q[7:0] == 8'h0);
         end
      end
   endtask

   always @(posedge clk) begin
      logic zero;
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_res = '0; m_n = 0; m_z = 0; m_dbz = 0; m_left = 0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
               m_busy = 0; m_done = 1; m_res = p_res; m_n = p_n; m_z = p_z;
            end
         end else if (start) begin
            compute(size_word, signed_mode, dividend, divisor, zero);
            m_dbz = zero;
            if (zero) m_done = 1;
            else begin
               m_busy = 1;
               m_left = size_word ? 32 : 16;
            end
         end
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R6", "busy", 32'(busy), 32'(m_busy));
         chk("R6", "done", 32'(done), 32'(m_done));
         chk("R7", "div_by_zero", 32'(div_by_zero), 32'(m_dbz));
         chk(tag, "result", result, m_res);
         chk("R4", "flag_n", 32'(flag_n), 32'(m_n));
         chk("R5", "flag_z", 32'(flag_z), 32'(m_z));
      end
   end

   task automatic run_op(input string t, input logic sz, input logic sg,
                         input logic [31:0] a, input logic [15:0] b, input bit poke);
      @(negedge clk);
      tag = t;
      size_word = sz; signed_mode = sg; dividend = a; divisor = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R8: a start while busy with different operands must be ignored
         repeat (3) @(negedge clk);
         dividend = 32'h1234_5678; divisor = 16'h0003; size_word = ~sz; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (m_busy) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", "busy", 32'(busy), 0);
      chk("R9", "done", 32'(done), 0);
      chk("R9", "result", result, 0);
      chk("R9", "flags", {29'h0, flag_n, flag_z, div_by_zero}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_op("R1", 0, 0, 32'd1000, 16'd7, 0);          // q=142 r=6, N=1
      run_op("R1", 0, 0, 32'h0000_FFFF, 16'h0001, 0);  // q low byte FF
      run_op("R5", 0, 0, 32'd3, 16'd7, 0);             // q=0, Z=1
      run_op("R2", 1, 0, 32'd100000, 16'd300, 0);
      run_op("R2", 1, 0, 32'hFFFF_FFFF, 16'hFFFF, 0);
      run_op("R3", 0, 1, 32'h0000_FFF9, 16'h0002, 0);  // -7/2 -> q=-3 r=-1
      run_op("R3", 0, 1, 32'd7, 16'h00FE, 0);          // 7/-2 -> q=-3 r=1
      run_op("R3", 0, 1, 32'h0000_FFF9, 16'h00FE, 0);  // -7/-2 -> q=3 r=-1
      run_op("R3", 1, 1, -32'sd100000, 16'd7, 0);
      run_op("R3", 1, 1, 32'h8000_0000, 16'hFFFF, 0);  // quotient 2^31, low half 0
      run_op("R4", 1, 1, 32'd70000, 16'hFFFE, 0);
      run_op("R7", 0, 0, 32'd55, 16'h0100, 0);         // byte divisor field zero
      run_op("R7", 1, 1, 32'd55, 16'h0000, 0);
      run_op("R7", 0, 1, 32'd55, 16'h0005, 0);         // clears div_by_zero
      run_op("R8", 1, 0, 32'd987654, 16'd321, 1);
      run_op("R8", 0, 1, 32'h0000_8000, 16'h0081, 1);
      for (int i = 0; i < 60; i++) begin
         logic [31:0] a;
         logic [15:0] b;
         a = $urandom;
         b = (i % 9 == 0) ? 16'h0 : 16'($urandom);
         run_op((i % 2) ? "R2" : "R1", 1'(i % 2), 1'((i / 2) % 2), a, b, (i % 7 == 0));
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      while (cycles < 100000) @(posedge clk);
      bad++;
      $display("FAIL R6 watchdog act=%0d exp=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule